// File: doc/BRIEF.md
# DMA Transfer Configuration and End-of-Transfer Controller

This block keeps a 16-bit DMA setup word for a full-speed USB device and decides when a DMA transfer is over. Firmware reaches the word through a byte-wide command port. A command strobe carries an opcode. Data-byte strobes then move the two bytes of the word, low byte first. The word selects the target endpoint, the burst-length code, DMA enable, auto-restart, counter-based termination and short-packet termination.

A transfer can end in two ways, and each has its own enable bit. One is a 16-bit byte counter that reaches zero. The other is an OUT packet that arrives shorter than the maximum packet size. When short-packet mode is on and an IN transfer finishes exactly on a full-size packet, the block asks the endpoint logic for a closing empty packet. When a transfer ends, the block either drops DMA enable or, if auto-restart is set, reloads the counter and keeps running. A USB bus reset clears only the enable bit and the auto-restart bit.

The command sequencer is a five-state machine. `ST_IDLE` moves to `ST_WR_LO` on opcode 0xF0 and to `ST_RD_LO` on opcode 0xF1. `ST_WR_LO` moves to `ST_WR_HI` on a data strobe. `ST_WR_HI` commits the word and returns to `ST_IDLE` on a data strobe. `ST_RD_LO` moves to `ST_RD_HI` on a data strobe. `ST_RD_HI` returns to `ST_IDLE` on a data strobe. A command strobe in any state restarts the machine from the new opcode. Any opcode other than 0xF0 or 0xF1 sends the machine to `ST_IDLE`.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every configuration bit is zero. `dma_en`, `ep_index`, `burst_code`, `rd_data`, `eot_pulse` and `zlp_req` are all zero.
- R2: Opcode 0xF0 is followed by two data strobes, low byte then high byte. The new word takes effect at the edge of the second byte and not before. Low byte layout: bits 7:4 are the endpoint index, bit 3 is DMA enable, bit 2 is auto-restart, and bits 1:0 are the burst code.
- R3: After opcode 0xF1, `rd_data` shows the low byte. After one data strobe it shows the high byte. After a second data strobe it shows zero. It shows zero whenever no read is in progress.
- R4: In the high byte, bit 7 is the counter-end enable and bit 6 is the short-packet enable. High-byte bits 5:0 (word bits 13:8) are not stored and always read as zero.
- R5: A `bus_reset` pulse clears DMA enable and auto-restart and leaves every other bit as it was. If a write commits in the same cycle, the reset still clears those two bits.
- R6: `cnt_load` loads the byte counter and also stores that value as the reload value. Each `xfer_stb` while DMA is enabled decrements the counter by one, and it stops at zero. Strobes while DMA is disabled leave the counter unchanged. A load in the same cycle takes priority over a strobe.
- R7: When the counter-end bit is set, a strobe that takes the counter from 1 to 0 makes `eot_pulse` high for exactly the next cycle.
- R8: When the short-packet bit is set and DMA is enabled, a `pkt_end` with `pkt_in`=0 and `pkt_len` < `pkt_max` (a zero length included) gives `eot_pulse` in the next cycle. A `pkt_len` equal to `pkt_max` gives none, and so does any packet with `pkt_in`=1.
- R9: When the short-packet bit is set and DMA is enabled, a `pkt_end` with `pkt_in`=1, `pkt_len` equal to `pkt_max` and the counter at zero gives a one-cycle `zlp_req` in the next cycle. If the counter is not zero, there is no request.
- R10: At the edge where an end of transfer is registered, DMA enable is cleared if auto-restart is clear. If auto-restart is set, the counter reloads its last loaded value and DMA enable stays set.
- R11: If the counter end and a short OUT packet occur in the same cycle, exactly one single-cycle `eot_pulse` results.
- R12: Opcodes other than 0xF0 and 0xF1 change nothing. A new command strobe in the middle of an access abandons that access.
- R13: While DMA enable is zero, `pkt_end` causes neither `eot_pulse` nor `zlp_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command opcode strobe |
| cmd_code | input | 8 | Command opcode |
| data_stb | input | 1 | Data byte strobe (write or read advance) |
| data_in | input | 8 | Write data byte |
| rd_data | output | 8 | Read-back byte |
| bus_reset | input | 1 | USB bus reset pulse |
| cnt_load | input | 1 | Load byte counter |
| cnt_load_val | input | CNT_W | Counter load value |
| xfer_stb | input | 1 | One DMA byte moved |
| pkt_end | input | 1 | Packet finished |
| pkt_in | input | 1 | Packet direction: 1 = IN, 0 = OUT |
| pkt_len | input | LEN_W | Finished packet length |
| pkt_max | input | LEN_W | Endpoint maximum packet size |
| dma_en | output | 1 | DMA enable |
| ep_index | output | 4 | Selected endpoint index |
| burst_code | output | 2 | Burst-length code |
| eot_pulse | output | 1 | One-cycle end-of-transfer |
| zlp_req | output | 1 | One-cycle request for an empty IN packet |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the counter reaching zero and a short OUT packet ending. The bench loads a count of one and then drives the final `xfer_stb` and a short `pkt_end` on the same edge. It judges the result by seeing one `eot_pulse` followed by a low cycle. The second pair is a bus reset and a write commit. The bench raises `bus_reset` on the edge of the second write byte. It then requires the enable and auto-restart bits to be zero on the outputs and in the read-back, while the other written fields hold their new values.

// File: rtl/dmaeot_pkg.sv
package dmaeot_pkg;
    localparam logic [7:0] OPC_CFG_WR = 8'hF0;
    localparam logic [7:0] OPC_CFG_RD = 8'hF1;
    localparam int CFG_W   = 16;
    localparam int EP_W    = 4;
    localparam int BURST_W = 2;
    // bit positions inside the configuration word
    localparam int B_CNTEOT = 15;
    localparam int B_SHORT  = 14;
    localparam int B_EP_LSB = 4;
    localparam int B_EN     = 3;
    localparam int B_AUTO   = 2;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI
    } cmd_state_e;
endpackage

// File: rtl/dmaeot_cmd_seq.sv
module dmaeot_cmd_seq
    import dmaeot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic [7:0]       cmd_code,
    input  logic             data_stb,
    input  logic [7:0]       data_in,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [7:0]       rd_data,
    output logic             commit,
    output logic [CFG_W-1:0] commit_word
);
    cmd_state_e state_q, state_d;
    logic [7:0] lo_hold_q;

    // state register and low-byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lo_hold_q <= '0;
        end else begin
            state_q <= state_d;
            if (!cmd_stb && data_stb && state_q == ST_WR_LO)
                lo_hold_q <= data_in;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_stb) begin
            if (cmd_code == OPC_CFG_WR)      state_d = ST_WR_LO;
            else if (cmd_code == OPC_CFG_RD) state_d = ST_RD_LO;
            else                             state_d = ST_IDLE;
        end else if (data_stb) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WR_LO: state_d = ST_WR_HI;
                ST_WR_HI: state_d = ST_IDLE;
                ST_RD_LO: state_d = ST_RD_HI;
                ST_RD_HI: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        rd_data = '0;
        commit  = 1'b0;
        unique case (state_q)
            ST_RD_LO: rd_data = cfg_word[7:0];
            ST_RD_HI: rd_data = cfg_word[15:8];
            ST_WR_HI: commit  = data_stb && !cmd_stb;
            default:  rd_data = '0;
        endcase
    end

    assign commit_word = {data_in, lo_hold_q};
endmodule

// File: rtl/dmaeot_counter.sv
module dmaeot_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] reload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            reload_q <= '0;
        end else if (load) begin
            cnt      <= load_val;
            reload_q <= load_val;
        end else if (restart) begin
            cnt <= reload_q;
        end else if (dec_en && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dmaeot_end_detect.sv
module dmaeot_end_detect #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 11
) (
    input  logic             dma_en,
    input  logic             cnt_eot_en,
    input  logic             short_en,
    input  logic             cnt_load,
    input  logic             xfer_stb,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pkt_end,
    input  logic             pkt_in,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] pkt_max,
    output logic             eot_now,
    output logic             zlp_now
);
    logic last_byte;
    logic short_out;
    logic full_in;

    always_comb begin
        last_byte = dma_en && xfer_stb && !cnt_load && (cnt == CNT_W'(1));
        short_out = short_en && dma_en && pkt_end && !pkt_in && (pkt_len < pkt_max);
        full_in   = short_en && dma_en && pkt_end && pkt_in && (pkt_len == pkt_max);
        eot_now   = (cnt_eot_en && last_byte) || short_out;
        zlp_now   = full_in && (cnt == '0);
    end
endmodule

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl
    import dmaeot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic [7:0]       cmd_code,
    input  logic             data_stb,
    input  logic [7:0]       data_in,
    output logic [7:0]       rd_data,
    input  logic             bus_reset,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    input  logic             xfer_stb,
    input  logic             pkt_end,
    input  logic             pkt_in,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] pkt_max,
    output logic             dma_en,
    output logic [3:0]       ep_index,
    output logic [1:0]       burst_code,
    output logic             eot_pulse,
    output logic             zlp_req
);
    logic               cfg_cnteot_q, cfg_short_q, cfg_en_q, cfg_auto_q;
    logic [EP_W-1:0]    cfg_ep_q;
    logic [BURST_W-1:0] cfg_burst_q;
    logic [CFG_W-1:0]   cfg_word, commit_word;
    logic               commit, eot_now, zlp_now;
    logic [CNT_W-1:0]   cnt_q;

    assign cfg_word = {cfg_cnteot_q, cfg_short_q, 6'b0, cfg_ep_q, cfg_en_q, cfg_auto_q, cfg_burst_q};

    dmaeot_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .data_stb(data_stb), .data_in(data_in), .cfg_word(cfg_word),
        .rd_data(rd_data), .commit(commit), .commit_word(commit_word)
    );

    dmaeot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
        .restart(eot_now && cfg_auto_q), .dec_en(cfg_en_q && xfer_stb), .cnt(cnt_q)
    );

    dmaeot_end_detect #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_end (
        .dma_en(cfg_en_q), .cnt_eot_en(cfg_cnteot_q), .short_en(cfg_short_q),
        .cnt_load(cnt_load), .xfer_stb(xfer_stb), .cnt(cnt_q),
        .pkt_end(pkt_end), .pkt_in(pkt_in), .pkt_len(pkt_len), .pkt_max(pkt_max),
        .eot_now(eot_now), .zlp_now(zlp_now)
    );

    // configuration fields untouched by bus reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_cnteot_q <= 1'b0;
            cfg_short_q  <= 1'b0;
            cfg_ep_q     <= '0;
            cfg_burst_q  <= '0;
        end else if (commit) begin
            cfg_cnteot_q <= commit_word[B_CNTEOT];
            cfg_short_q  <= commit_word[B_SHORT];
            cfg_ep_q     <= commit_word[B_EP_LSB +: EP_W];
            cfg_burst_q  <= commit_word[BURST_W-1:0];
        end
    end

    // enable and auto-restart: bus reset > write > end of transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en_q   <= 1'b0;
            cfg_auto_q <= 1'b0;
        end else if (bus_reset) begin
            cfg_en_q   <= 1'b0;
            cfg_auto_q <= 1'b0;
        end else if (commit) begin
            cfg_en_q   <= commit_word[B_EN];
            cfg_auto_q <= commit_word[B_AUTO];
        end else if (eot_now && !cfg_auto_q) begin
            cfg_en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eot_pulse <= 1'b0;
            zlp_req   <= 1'b0;
        end else begin
            eot_pulse <= eot_now;
            zlp_req   <= zlp_now;
        end
    end

    assign dma_en     = cfg_en_q;
    assign ep_index   = cfg_ep_q;
    assign burst_code = cfg_burst_q;
endmodule

// File: rtl/dmaeot_chk.sv
module dmaeot_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             data_stb,
    input logic             dma_en,
    input logic             auto_q,
    input logic             eot_pulse,
    input logic             zlp_req,
    input logic             pkt_end,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_val
);
    // R5
    breset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !dma_en);
    // R10
    eot_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_pulse && !$past(auto_q) && !$past(data_stb) && !$past(bus_reset)) |-> !dma_en);
    // R13
    eot_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> $past(dma_en));
    // R9
    zlp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_req |-> ($past(pkt_end) && $past(dma_en)));
    // R6
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load |=> (eot_pulse || cnt_val <= $past(cnt_val)));
endmodule

bind dma_eot_ctrl dmaeot_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .data_stb(data_stb),
    .dma_en(dma_en), .auto_q(cfg_auto_q), .eot_pulse(eot_pulse), .zlp_req(zlp_req),
    .pkt_end(pkt_end), .cnt_load(cnt_load), .cnt_val(cnt_q)
);

// File: tb/dma_eot_ctrl_tb_top.sv
module dma_eot_ctrl_tb_top;
    localparam int CW = 16;
    localparam int LW = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_stb = 0, data_stb = 0, bus_reset = 0, cnt_load = 0, xfer_stb = 0;
    logic pkt_end = 0, pkt_in = 0;
    logic [7:0] cmd_code = 0, data_in = 0, rd_data;
    logic [CW-1:0] cnt_load_val = 0;
    logic [LW-1:0] pkt_len = 0, pkt_max = 0;
    logic dma_en, eot_pulse, zlp_req;
    logic [3:0] ep_index;
    logic [1:0] burst_code;

    int vectors = 0, fails = 0;

    always #5 clk = ~clk;

    dma_eot_ctrl #(.CNT_W(CW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .data_stb(data_stb), .data_in(data_in), .rd_data(rd_data),
        .bus_reset(bus_reset), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .xfer_stb(xfer_stb), .pkt_end(pkt_end), .pkt_in(pkt_in),
        .pkt_len(pkt_len), .pkt_max(pkt_max), .dma_en(dma_en), .ep_index(ep_index),
        .burst_code(burst_code), .eot_pulse(eot_pulse), .zlp_req(zlp_req)
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_cnteot, m_short, m_en, m_auto, m_eot, m_zlp;
    int m_ep, m_burst, m_cnt, m_rel, m_phase, m_hold;

    function automatic int m_rd();
        if (m_phase == 3) return (m_ep << 4) | (int'(m_en) << 3) | (int'(m_auto) << 2) | m_burst;
        if (m_phase == 4) return (int'(m_cnteot) << 7) | (int'(m_short) << 6);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnteot = 0; m_short = 0; m_en = 0; m_auto = 0; m_eot = 0; m_zlp = 0;
            m_ep = 0; m_burst = 0; m_cnt = 0; m_rel = 0; m_phase = 0; m_hold = 0;
        end else begin
            bit e, z, wr;
            int word;
            e = (m_cnteot && m_en && xfer_stb && !cnt_load && m_cnt == 1) ||
                (m_short && m_en && pkt_end && !pkt_in && pkt_len < pkt_max);
            z = m_short && m_en && pkt_end && pkt_in && pkt_len == pkt_max && m_cnt == 0;
            if (cnt_load) begin m_cnt = int'(cnt_load_val); m_rel = m_cnt; end
            else if (e && m_auto) m_cnt = m_rel;
            else if (m_en && xfer_stb && m_cnt > 0) m_cnt--;
            wr = 0; word = 0;
            if (cmd_stb) m_phase = (cmd_code == 8'hF0) ? 1 : (cmd_code == 8'hF1) ? 3 : 0;
            else if (data_stb) begin
                case (m_phase)
                    1: begin m_hold = int'(data_in); m_phase = 2; end
                    2: begin wr = 1; word = (int'(data_in) << 8) | m_hold; m_phase = 0; end
                    3: m_phase = 4;
                    default: m_phase = 0;
                endcase
            end
            if (wr) begin
                m_cnteot = word[15]; m_short = word[14];
                m_ep = (word >> 4) & 15; m_burst = word & 3;
            end
            if (bus_reset) begin m_en = 0; m_auto = 0; end
            else if (wr) begin m_en = word[3]; m_auto = word[2]; end
            else if (e && !m_auto) m_en = 0;
            m_eot = e; m_zlp = z;
        end
    end

    // per-cycle compare away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 rd_data", int'(rd_data), m_rd());
            chk("R5 dma_en", int'(dma_en), int'(m_en));
            chk("R2 ep_index", int'(ep_index), m_ep);
            chk("R2 burst_code", int'(burst_code), m_burst);
            chk("R7 eot_pulse", int'(eot_pulse), int'(m_eot));
            chk("R9 zlp_req", int'(zlp_req), int'(m_zlp));
        end
    end

    task automatic step();
        @(posedge clk); #1;
        cmd_stb = 0; data_stb = 0; bus_reset = 0; cnt_load = 0; xfer_stb = 0; pkt_end = 0;
    endtask
    task automatic cmd(input logic [7:0] c);
        cmd_stb = 1; cmd_code = c; step();
    endtask
    task automatic dbyte(input logic [7:0] d);
        data_stb = 1; data_in = d; step();
    endtask
    task automatic wr_cfg(input logic [7:0] lo, input logic [7:0] hi);
        cmd(8'hF0); dbyte(lo); dbyte(hi);
    endtask
    task automatic load(input int v);
        cnt_load = 1; cnt_load_val = CW'(v); step();
    endtask
    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin xfer_stb = 1; step(); end
    endtask
    task automatic pkt(input int len, input int mx, input bit inb);
        pkt_end = 1; pkt_len = LW'(len); pkt_max = LW'(mx); pkt_in = inb; step();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        // R1 reset state
        chk("R1 en", int'(dma_en), 0); chk("R1 ep", int'(ep_index), 0);
        chk("R1 rd", int'(rd_data), 0); chk("R1 eot", int'(eot_pulse), 0);
        // R2 write takes effect only after second byte
        cmd(8'hF0); dbyte(8'h5E);
        chk("R2 early en", int'(dma_en), 0); chk("R2 early ep", int'(ep_index), 0);
        dbyte(8'hFF);
        chk("R2 ep", int'(ep_index), 5); chk("R2 en", int'(dma_en), 1);
        chk("R2 burst", int'(burst_code), 2);
        // R3 / R4 read-back
        cmd(8'hF1); chk("R3 lo", int'(rd_data), 'h5E);
        dbyte(0);   chk("R4 hi reserved zero", int'(rd_data), 'hC0);
        dbyte(0);   chk("R3 done", int'(rd_data), 0);
        // R12 unknown opcode and aborted write
        cmd(8'h33); dbyte(8'h00); dbyte(8'h00);
        chk("R12 ep kept", int'(ep_index), 5); chk("R12 en kept", int'(dma_en), 1);
        cmd(8'hF0); dbyte(8'h00); cmd(8'hF1);
        chk("R12 abort", int'(rd_data), 'h5E);
        // R7 / R10 counter end with auto-restart
        load(3); strobe(2); chk("R7 no early eot", int'(eot_pulse), 0);
        strobe(1); chk("R7 eot", int'(eot_pulse), 1); chk("R10 en kept", int'(dma_en), 1);
        step(); chk("R7 one cycle", int'(eot_pulse), 0);
        strobe(2); strobe(1); chk("R10 reloaded", int'(eot_pulse), 1);
        // R10 without auto-restart
        wr_cfg(8'h58, 8'h80); load(2); strobe(1); strobe(1);
        chk("R7 eot", int'(eot_pulse), 1); chk("R10 en cleared", int'(dma_en), 0);
        strobe(1); chk("R13 no eot disabled", int'(eot_pulse), 0);
        // R6 strobes ignored while disabled
        load(2); wr_cfg(8'h50, 8'h80); strobe(3); wr_cfg(8'h58, 8'h80);
        strobe(1); chk("R6 held count", int'(eot_pulse), 0);
        strobe(1); chk("R6 reached zero", int'(eot_pulse), 1);
        // R8 short OUT packets
        wr_cfg(8'h5C, 8'h40);
        pkt(10, 64, 0); chk("R8 short", int'(eot_pulse), 1);
        pkt(0, 64, 0);  chk("R8 empty", int'(eot_pulse), 1);
        pkt(64, 64, 0); chk("R8 full", int'(eot_pulse), 0);
        pkt(10, 64, 1); chk("R8 IN short", int'(eot_pulse), 0);
        // R9 empty IN packet request
        load(2); strobe(2);
        pkt(64, 64, 1); chk("R9 zlp", int'(zlp_req), 1); chk("R9 no eot", int'(eot_pulse), 0);
        step(); chk("R9 one cycle", int'(zlp_req), 0);
        load(5); pkt(64, 64, 1); chk("R9 count nonzero", int'(zlp_req), 0);
        // R11 both causes in one cycle
        wr_cfg(8'h5C, 8'hC0); load(1);
        xfer_stb = 1; pkt_end = 1; pkt_len = 8; pkt_max = 64; pkt_in = 0; step();
        chk("R11 eot", int'(eot_pulse), 1);
        step(); chk("R11 single", int'(eot_pulse), 0);
        // R13 packet end while disabled
        wr_cfg(8'h50, 8'h40); pkt(8, 64, 0);
        chk("R13 ignored", int'(eot_pulse), 0);
        // R5 bus reset
        wr_cfg(8'h5E, 8'hC0); bus_reset = 1; step();
        chk("R5 en", int'(dma_en), 0); chk("R5 ep", int'(ep_index), 5);
        chk("R5 burst", int'(burst_code), 2);
        cmd(8'hF1); chk("R5 lo", int'(rd_data), 'h52);
        dbyte(0);   chk("R5 hi", int'(rd_data), 'hC0);
        cmd(8'hF0); dbyte(8'h6D); bus_reset = 1; dbyte(8'h40);
        chk("R5 with commit", int'(dma_en), 0); chk("R5 ep new", int'(ep_index), 6);
        cmd(8'hF1); chk("R5 lo after commit", int'(rd_data), 'h61);
        step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule